// File: doc/BRIEF.md
# Write-Only Two-Wire Configuration Slave

This block is a receive-only serial slave that fills a small bank of byte-wide configuration registers for a clock generator. It oversamples the two bus wires with a fast system clock. It finds start and stop conditions and shifts bytes in, most significant bit first. When it accepts a byte, it answers with an acknowledge by pulling the data wire low through an output-enable.

A transaction opens with an address byte. Only the exact value 0xD2 is accepted; that value carries a write direction in its least significant bit. The two bytes after the address are a command byte and a count byte. Both are acknowledged and then thrown away. Every data byte after them goes into the next register, starting at register 0. The bank holds a fixed number of registers. Data beyond that number is refused, and so are bytes that follow any refused byte. Registers that a transaction does not reach keep their contents. Only the reset input restores the power-up values.

The register bank is presented as one flat parallel bus, so the clock-generator logic can decode each byte directly.

Top module: `cfg_twowire_slave`

## Requirements
- R1: A falling data line while the clock line is high starts a transaction. A rising data line while the clock line is high ends it, and the acknowledge drive is released.
- R2: Bits are taken on the rising clock edges, most significant bit first, so a register holds the byte exactly as it was sent (for example 0x81 reads back as 0x81).
- R3: Only the address byte 0xD2 is acknowledged. After any other address, no byte of that transaction is acknowledged and no register changes.
- R4: After each accepted byte, `sda_oe` is high during the ninth clock pulse. It changes only while the clock line is low and is low at every other time.
- R5: The command byte and the count byte after a matching address are both acknowledged, and neither changes any register.
- R6: The data bytes go to register 0, then 1, then 2, in order. Register k sits at `cfg_regs[8k+7:8k]`.
- R7: At most NREG (default 10) data bytes are accepted. The next data byte, and every byte after it up to the stop, is not acknowledged and changes nothing.
- R8: Registers that a transaction does not reach keep their previous values.
- R9: Reset loads register 0 with 0xF0 and every other register with 0xFF, and holds `sda_oe` low.
- R10: A stop in the middle of a byte discards that partial byte. A repeated start begins a new address phase, and the data after it goes to register 0 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low power-on reset |
| scl_i | input | 1 | Bus clock line as seen at the pin (pulled up) |
| sda_i | input | 1 | Bus data line as seen at the pin (pulled up) |
| sda_oe | output | 1 | When high, the pad pulls the data line low (acknowledge) |
| cfg_regs | output | NREG*8 | Register bank; register k in bits 8k+7..8k |

## Verification
The checker watches several rules on every cycle. The acknowledge enable may toggle only while the synchronized clock is low, and it is asserted only in the acknowledge phase. At most one register write strobe fires in a cycle, and only when a byte has been accepted. The bank never changes without a strobe. Start and stop conditions always release the data line. The bench's scenarios are needed to show the rest: the address filter, the discarding of the two header bytes, the order of data placement, the refusal past the last register, and the effects of a stop mid-byte and of a repeated start.

// File: rtl/cfg_tw_pkg.sv
`timescale 1ns/1ps
package cfg_tw_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RECV = 2'd1,
    ST_ACK  = 2'd2,
    ST_SKIP = 2'd3
  } tw_state_e;

  // Bytes between the address and the first data byte.
  localparam int unsigned HDR_BYTES = 2;

  // Power-up content of register idx.
  function automatic logic [7:0] reset_byte(input int unsigned idx);
    return (idx == 0) ? 8'hF0 : 8'hFF;
  endfunction

  // Whether the byte at position pos (0 = address) should be acknowledged.
  function automatic logic keep_byte(input int unsigned pos,
                                     input logic [7:0]  val,
                                     input logic [7:0]  dev,
                                     input int unsigned nreg);
    if (pos == 0) return (val == dev);
    return (pos < HDR_BYTES + 1 + nreg);
  endfunction

endpackage

// File: rtl/tw_bus_sync.sv
`timescale 1ns/1ps
module tw_bus_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [SYNC_STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;

  // Idle-high reset mirrors the bus pull-ups.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  assign scl_s     = scl_ff[SYNC_STAGES-1];
  assign sda_s     = sda_ff[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/tw_byte_engine.sv
`timescale 1ns/1ps
module tw_byte_engine
  import cfg_tw_pkg::*;
#(
  parameter logic [7:0]  DEV_ADDR = 8'hD2,
  parameter int unsigned NREG     = 10,
  localparam int unsigned POSW    = $clog2(NREG + HDR_BYTES + 2),
  localparam int unsigned IDXW    = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sda_s,
  input  logic            scl_rise,
  input  logic            scl_fall,
  input  logic            start_evt,
  input  logic            stop_evt,
  output logic            sda_oe,
  output tw_state_e       state,
  output logic            byte_done,
  output logic            byte_accept,
  output logic            wr_en,
  output logic [IDXW-1:0] wr_idx,
  output logic [7:0]      wr_data
);
  logic [2:0]      bit_cnt;
  logic [7:0]      shreg;
  logic [POSW-1:0] pos;
  logic            got_byte;
  logic            ack_pend;
  logic [7:0]      shift_next;

  assign shift_next  = {shreg[6:0], sda_s};
  assign byte_done   = (state == ST_RECV) && scl_rise && (bit_cnt == 3'd7);
  assign byte_accept = byte_done &&
                       keep_byte(int'(pos), shift_next, DEV_ADDR, NREG);
  assign wr_en       = byte_accept && (int'(pos) > int'(HDR_BYTES));
  assign wr_idx      = IDXW'(pos - POSW'(HDR_BYTES + 1));
  assign wr_data     = shift_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      shreg    <= '0;
      pos      <= '0;
      got_byte <= 1'b0;
      ack_pend <= 1'b0;
      sda_oe   <= 1'b0;
    end else if (start_evt) begin
      state    <= ST_RECV;
      bit_cnt  <= '0;
      pos      <= '0;
      got_byte <= 1'b0;
      ack_pend <= 1'b0;
      sda_oe   <= 1'b0;
    end else if (stop_evt) begin
      state    <= ST_IDLE;
      got_byte <= 1'b0;
      ack_pend <= 1'b0;
      sda_oe   <= 1'b0;
    end else begin
      unique case (state)
        ST_RECV: begin
          if (scl_rise) begin
            shreg   <= shift_next;
            bit_cnt <= bit_cnt + 3'd1;
            if (bit_cnt == 3'd7) begin
              got_byte <= 1'b1;
              ack_pend <= byte_accept;
            end
          end else if (scl_fall && got_byte) begin
            got_byte <= 1'b0;
            if (ack_pend) begin
              state  <= ST_ACK;
              sda_oe <= 1'b1;
            end else begin
              state  <= ST_SKIP;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            sda_oe   <= 1'b0;
            ack_pend <= 1'b0;
            bit_cnt  <= '0;
            pos      <= pos + POSW'(1);
            state    <= ST_RECV;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tw_reg_bank.sv
`timescale 1ns/1ps
module tw_reg_bank
  import cfg_tw_pkg::*;
#(
  parameter int unsigned NREG = 10,
  localparam int unsigned IDXW = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDXW-1:0]   wr_idx,
  input  logic [7:0]        wr_data,
  output logic [NREG-1:0]   we_vec,
  output logic [NREG*8-1:0] regs_flat
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [7:0] val;
    assign we_vec[g] = wr_en && (wr_idx == IDXW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         val <= reset_byte(g);
      else if (we_vec[g]) val <= wr_data;
    end
    assign regs_flat[g*8 +: 8] = val;
  end
endmodule

// File: rtl/cfg_twowire_slave.sv
`timescale 1ns/1ps
module cfg_twowire_slave
  import cfg_tw_pkg::*;
#(
  parameter logic [7:0]  DEV_ADDR    = 8'hD2,
  parameter int unsigned NREG        = 10,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned IDXW       = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [NREG*8-1:0] cfg_regs
);
  // Internal events, named for the checker.
  logic            scl_s, sda_s, scl_rise, scl_fall;
  logic            start_evt, stop_evt;
  logic            byte_done, byte_accept, wr_en;
  logic [IDXW-1:0] wr_idx;
  logic [7:0]      wr_data;
  logic [NREG-1:0] we_vec;
  tw_state_e       state;

  tw_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  tw_byte_engine #(.DEV_ADDR(DEV_ADDR), .NREG(NREG)) eng_i (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt),
    .sda_oe(sda_oe), .state(state),
    .byte_done(byte_done), .byte_accept(byte_accept),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  tw_reg_bank #(.NREG(NREG)) bank_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .we_vec(we_vec), .regs_flat(cfg_regs)
  );
endmodule

// File: rtl/tw_cfg_checker.sv
`timescale 1ns/1ps
module tw_cfg_checker
  import cfg_tw_pkg::*;
#(
  parameter int unsigned NREG = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_s,
  input logic              sda_oe,
  input logic              start_evt,
  input logic              stop_evt,
  input logic              byte_accept,
  input logic [NREG-1:0]   we_vec,
  input logic [NREG*8-1:0] cfg_regs,
  input tw_state_e         state
);
  p_release_on_stop_r1: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_oe);

  p_oe_moves_scl_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_s);

  p_oe_only_in_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> (state == ST_ACK));

  p_single_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(we_vec));

  p_write_needs_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|we_vec) |-> byte_accept);

  p_regs_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(|we_vec) |=> $stable(cfg_regs));

  p_start_releases_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !sda_oe);
endmodule

bind cfg_twowire_slave tw_cfg_checker #(.NREG(NREG)) chk_i (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe),
  .start_evt(start_evt), .stop_evt(stop_evt), .byte_accept(byte_accept),
  .we_vec(we_vec), .cfg_regs(cfg_regs), .state(state)
);

// File: tb/cfg_twowire_slave_tb.sv
`timescale 1ns/1ps
module cfg_twowire_slave_tb_top;
  localparam int NREG = 10;
  localparam int Q    = 4;   // system clocks per quarter bus bit
  localparam int NV   = 8;
  // {address[19:12], data count[11:8], seed[7:0]}
  localparam logic [19:0] VEC [NV] = '{
    {8'hD2, 4'd3,  8'h12},
    {8'hD3, 4'd2,  8'h77},
    {8'hA2, 4'd4,  8'h3C},
    {8'hD2, 4'd10, 8'h81},
    {8'hD2, 4'd12, 8'h5E},
    {8'hD2, 4'd0,  8'h00},
    {8'hD2, 4'd1,  8'hE7},
    {8'h52, 4'd2,  8'h19}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic sda_line;
  logic [NREG*8-1:0] cfg_regs;
  logic [7:0] model [NREG];
  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  cfg_twowire_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .cfg_regs(cfg_regs)
  );

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_start;
    sda_m = 1'b1; wclk(Q);
    scl_m = 1'b1; wclk(2*Q);
    sda_m = 1'b0; wclk(2*Q);
    scl_m = 1'b0; wclk(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; wclk(Q);
    scl_m = 1'b1; wclk(2*Q);
    sda_m = 1'b1; wclk(2*Q);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b;    wclk(2*Q);
    scl_m = 1'b1; wclk(2*Q);
    scl_m = 1'b0; wclk(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; wclk(2*Q);
    scl_m = 1'b1; wclk(Q);
    acked = ~sda_line;
    wclk(Q);
    scl_m = 1'b0; wclk(Q);
  endtask

  task automatic model_reset;
    for (int r = 0; r < NREG; r++) model[r] = (r == 0) ? 8'hF0 : 8'hFF;
  endtask

  task automatic cmp_bank(input string tag);
    for (int r = 0; r < NREG; r++) chk(tag, 32'(cfg_regs[r*8 +: 8]), 32'(model[r]));
  endtask

  initial begin
    wclk(180000);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic a;
    model_reset();
    wclk(5);
    // R9: power-up contents and released acknowledge
    cmp_bank("R9");
    chk("R9", 32'(sda_oe), 32'd0);
    rst_n = 1'b1;
    wclk(5);

    // Vector table: full transactions, R3/R5/R6/R7/R8
    for (int v = 0; v < NV; v++) begin
      logic [7:0] addr, seed;
      int nd;
      logic alive;
      addr = VEC[v][19:12];
      nd   = int'(VEC[v][11:8]);
      seed = VEC[v][7:0];
      alive = (addr == 8'hD2);
      bus_start();
      send_byte(addr, a);  chk("R3", 32'(a), 32'(alive));
      send_byte(8'hA5, a); chk("R5", 32'(a), 32'(alive));
      send_byte(8'(nd), a); chk("R5", 32'(a), 32'(alive));
      for (int k = 0; k < nd; k++) begin
        logic [7:0] d;
        logic ex;
        d  = seed ^ 8'(k * 53);
        ex = alive && (k < NREG);
        send_byte(d, a);
        chk(k >= NREG ? "R7" : "R6", 32'(a), 32'(ex));
        if (ex) model[k] = d;
      end
      bus_stop();
      wclk(Q);
      chk("R1", 32'(sda_oe), 32'd0);
      cmp_bank("R8");
    end

    // R2: bit order, both ends of the byte
    bus_start();
    send_byte(8'hD2, a); send_byte(8'h00, a); send_byte(8'h02, a);
    send_byte(8'h81, a); model[0] = 8'h81;
    send_byte(8'h01, a); model[1] = 8'h01;
    bus_stop(); wclk(Q);
    chk("R2", 32'(cfg_regs[7:0]), 32'h81);
    chk("R2", 32'(cfg_regs[15:8]), 32'h01);

    // R10: stop in the middle of a data byte discards it
    bus_start();
    send_byte(8'hD2, a); send_byte(8'h00, a); send_byte(8'h01, a);
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
    bus_stop(); wclk(Q);
    cmp_bank("R10");

    // R10: repeated start goes back to the address phase and register 0
    bus_start();
    send_byte(8'hD2, a); send_byte(8'h00, a); send_byte(8'h01, a);
    send_byte(8'h5A, a); chk("R10", 32'(a), 32'd1);
    bus_start();
    send_byte(8'hD2, a); chk("R10", 32'(a), 32'd1);
    send_byte(8'h00, a); send_byte(8'h01, a);
    send_byte(8'hC3, a); model[0] = 8'hC3;
    bus_stop(); wclk(Q);
    cmp_bank("R10");

    // R9: reset brings back the power-up values
    rst_n = 1'b0; wclk(3);
    model_reset();
    cmp_bank("R9");
    rst_n = 1'b1; wclk(3);
    cmp_bank("R9");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule